// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the standard 64-byte header of one configuration function on a PCI-style bus. It contains the fixed identification fields and the writable control fields. It also holds six base address registers (BARs), an expansion ROM register and the interrupt fields. Software reaches the header through a plain register port. Each access gives an offset, a size of 1, 2 or 4 bytes, a direction and write data. One cycle later the block returns a registered response carrying read data and an error flag.

Each BAR has a power-of-two size given by a parameter. Writing all ones to a BAR starts the sizing handshake: the BAR then reads back its size mask, and its address decoding stays as it was. Any other write keeps the BAR's low type bits. When the masked value is nonzero, it becomes the BAR's decoded base. A BAR can instead be marked as legacy I/O. Such a BAR sits at a fixed address, reads as zero and ignores writes.

For every BAR the block exports the decoded base and an enable. A downstream address decoder can use these outputs. The block also offers a per-BAR hit signal for an input probe address.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, every field holds its parameter value. The reserved bytes 0x34 to 0x3B read as zero. Every non-legacy BAR has a decoded base of 0 with its enable low.
- R2: Each access presented with `acc_valid` produces exactly one `resp_valid` pulse on the next clock edge. No response appears without an access.
- R3: A read of size 1, 2 or 4 returns the bytes starting at the given offset in little-endian order, zero-extended to 32 bits. Field offsets are as follows:
  - 0x00: vendor ID (16 bits), followed by device ID at 0x02.
  - 0x04: command (16 bits), followed by status at 0x06.
  - 0x08: revision, then programming interface, subclass and class code (one byte each).
  - 0x0C: cache line size, then latency timer, header type and BIST (one byte each).
  - 0x10 + 4·n: BAR n.
  - 0x28: card information pointer.
  - 0x2C: subsystem vendor ID (16 bits), followed by subsystem ID at 0x2E.
  - 0x30: expansion ROM register.
  - 0x3C: interrupt line, then interrupt pin, minimum grant and maximum latency (one byte each).
- R4: An access raises `resp_err` if its size is not 1, 2 or 4, or if its offset is 0x40 or higher. Such an access returns zero data and changes no state.
- R5: A byte write updates only the interrupt line (0x3C), the cache line size (0x0C) or the latency timer (0x0D). A byte write to 0x08, 0x0B, 0x3D, 0x3E or 0x3F is ignored without error. A byte write to any other offset raises `resp_err`.
- R6: A halfword write to 0x04 sets the command register and one to 0x06 sets the status register. A halfword write to 0x0C sets the cache line size from the low byte and leaves the latency timer unchanged. A halfword write to any other offset raises `resp_err`.
- R7: A word write to 0x04 loads the command register from the low 16 bits and leaves status unchanged. Word writes to a BAR or to 0x30 are accepted. A word write to any other in-range offset is ignored without error.
- R8: A word write of 0xFFFFFFFF to a non-legacy BAR makes it read back as ~(size−1), with the old low type bits kept. The decoded base and enable do not change.
- R9: For any other non-legacy BAR write, the type mask depends on bit 0 of the old BAR value: if that bit is 1 the mask is 0x3, otherwise it is 0xF. The BAR reads back as (new & ~mask) | (old & mask). A nonzero (new & ~mask) becomes the decoded base, and the enable rises. A zero value leaves the decoded base unchanged.
- R10: A legacy BAR always reads as zero and ignores writes without error. It exports its fixed parameter address with its enable high, and it never asserts its hit signal.
- R11: A word write of 0xFFFFFFFE to the expansion ROM register makes it read 0xFFFFFFFF. Any other value written there is stored unchanged.
- R12: `bar_hit[n]` is high only when all of the following hold:
  - BAR n is non-legacy.
  - BAR n has a nonzero size.
  - BAR n's decoded base is nonzero.
  - `probe_addr` lies within base to base+size−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset into the header |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data, right-aligned |
| resp_valid | output | 1 | Response strobe, one cycle after the access |
| resp_err | output | 1 | Access was rejected |
| resp_data | output | 32 | Read data, zero-extended |
| probe_addr | input | 32 | Address checked against the BAR windows |
| bar_base | output | 192 | Decoded base per BAR, BAR n in bits 32n+31:32n |
| bar_en | output | 6 | Decoded base valid per BAR |
| bar_hit | output | 6 | Probe address falls in the BAR window |

## Verification
The assertions assume the following about the block's inputs:
- The port carries at most one access per cycle, and `acc_valid` is always a known value.
- `acc_wdata` is right-aligned for the given size.
- `probe_addr` only matters through the combinational hit outputs.

The bench keeps within these assumptions in two ways. It presents every access as a single one-cycle strobe driven on the falling edge, followed by an idle cycle. It changes the probe address only between accesses and reads the hit outputs before the next edge.

// File: rtl/cfg_header_regs.sv
`timescale 1ns/1ps
module cfg_header_regs #(
  parameter int NUM_BARS = 6,
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h0A51,
  parameter logic [15:0] CMD_INIT   = 16'h0000,
  parameter logic [15:0] STAT_INIT  = 16'h0290,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h058012,
  parameter logic [7:0]  CACHE_INIT = 8'h10,
  parameter logic [7:0]  LAT_INIT   = 8'h40,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  BIST_INIT  = 8'h00,
  parameter logic [31:0] CIS_PTR    = 32'h0,
  parameter logic [15:0] SUB_VENDOR = 16'hC0DF,
  parameter logic [15:0] SUB_ID     = 16'h0001,
  parameter logic [31:0] ROM_INIT   = 32'h0,
  parameter logic [7:0]  IRQ_LINE   = 8'h0B,
  parameter logic [7:0]  IRQ_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h22,
  parameter logic [7:0]  MAX_LAT    = 8'h33,
  parameter logic [NUM_BARS*32-1:0] BAR_INIT =
    {32'h1, 32'h0, 32'h0, 32'h0, 32'h1, 32'h8},
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE =
    {32'h10, 32'h1000, 32'h0, 32'h0, 32'h20, 32'h100},
  parameter logic [NUM_BARS-1:0] LEGACY_MASK = 6'b000100,
  parameter logic [NUM_BARS*32-1:0] LEGACY_ADDR =
    {32'h0, 32'h0, 32'h0, 32'h3F8, 32'h0, 32'h0}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic [7:0]               acc_addr,
  input  logic [2:0]               acc_size,
  input  logic [31:0]              acc_wdata,
  output logic                     resp_valid,
  output logic                     resp_err,
  output logic [31:0]              resp_data,
  input  logic [31:0]              probe_addr,
  output logic [NUM_BARS*32-1:0]   bar_base,
  output logic [NUM_BARS-1:0]      bar_en,
  output logic [NUM_BARS-1:0]      bar_hit
);
  localparam logic [31:0] IO_MASK  = 32'h3;
  localparam logic [31:0] MEM_MASK = 32'hF;
  localparam logic [7:0]  BAR_LO   = 8'h10;
  localparam logic [7:0]  BAR_HI   = BAR_LO + 8'(NUM_BARS * 4);

  logic [15:0] command_q, status_q;
  logic [7:0]  cache_q, lat_q, irq_line_q;
  logic [31:0] rom_q;
  logic [31:0] bar_q  [NUM_BARS];
  logic [31:0] base_q [NUM_BARS];
  logic [NUM_BARS*32-1:0] bars_rd;

  genvar g;
  generate
    for (g = 0; g < NUM_BARS; g++) begin : g_bar
      localparam logic [31:0] SZ = BAR_SIZE[g*32 +: 32];
      if (SZ != 0 && (SZ & (SZ - 1)) != 0) begin : g_bad_size
        $error("BAR size is not a power of two");
      end
      if (LEGACY_MASK[g]) begin : g_legacy
        assign bars_rd[g*32 +: 32]  = 32'h0;
        assign bar_base[g*32 +: 32] = LEGACY_ADDR[g*32 +: 32];
        assign bar_en[g]            = 1'b1;
        assign bar_hit[g]           = 1'b0;
      end else begin : g_normal
        logic [31:0] off;
        assign off                  = probe_addr - base_q[g];
        assign bars_rd[g*32 +: 32]  = bar_q[g];
        assign bar_base[g*32 +: 32] = base_q[g];
        assign bar_en[g]            = base_q[g] != 32'h0;
        assign bar_hit[g]           = (SZ != 0) && bar_en[g] &&
                                      (probe_addr >= base_q[g]) && (off < SZ);
      end
    end
  endgenerate

  logic [511:0] image, shifted;
  assign image = {MAX_LAT, MIN_GNT, IRQ_PIN, irq_line_q, 64'h0, rom_q,
                  SUB_ID, SUB_VENDOR, CIS_PTR, bars_rd,
                  BIST_INIT, HDR_TYPE, lat_q, cache_q, CLASS_CODE, REVISION,
                  status_q, command_q, DEVICE_ID, VENDOR_ID};
  assign shifted = image >> {acc_addr[5:0], 3'b000};

  logic bad;
  assign bad = (acc_size != 3'd1 && acc_size != 3'd2 && acc_size != 3'd4) ||
               (acc_addr >= 8'h40);

  logic [31:0] rd_val;
  always_comb begin
    case (acc_size)
      3'd1:    rd_val = {24'h0, shifted[7:0]};
      3'd2:    rd_val = {16'h0, shifted[15:0]};
      default: rd_val = shifted[31:0];
    endcase
  end

  logic       bar_sel;
  logic [7:0] bar_rel;
  logic [2:0] bar_idx;
  logic [31:0] bar_old, bar_mask, bar_size, bar_raw, bar_next;
  logic       sizing;
  assign bar_sel  = acc_addr >= BAR_LO && acc_addr < BAR_HI && acc_addr[1:0] == 2'b00;
  assign bar_rel  = acc_addr - BAR_LO;
  assign bar_idx  = bar_rel[4:2];
  assign bar_old  = bar_q[bar_idx];
  assign bar_size = BAR_SIZE[bar_idx*32 +: 32];
  assign bar_mask = bar_old[0] ? IO_MASK : MEM_MASK;
  assign sizing   = acc_wdata == 32'hFFFF_FFFF;
  assign bar_raw  = sizing ? ~(bar_size - 32'h1) : (acc_wdata & ~bar_mask);
  assign bar_next = (bar_raw & ~bar_mask) | (bar_old & bar_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      command_q  <= CMD_INIT;
      status_q   <= STAT_INIT;
      cache_q    <= CACHE_INIT;
      lat_q      <= LAT_INIT;
      irq_line_q <= IRQ_LINE;
      rom_q      <= ROM_INIT;
      for (int i = 0; i < NUM_BARS; i++) begin
        bar_q[i]  <= BAR_INIT[i*32 +: 32];
        base_q[i] <= 32'h0;
      end
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_data  <= 32'h0;
    end else begin
      resp_valid <= acc_valid;
      resp_err   <= 1'b0;
      resp_data  <= 32'h0;
      if (acc_valid) begin
        if (bad) begin
          resp_err <= 1'b1;
        end else if (!acc_write) begin
          resp_data <= rd_val;
        end else if (acc_size == 3'd1) begin
          case (acc_addr)
            8'h3C: irq_line_q <= acc_wdata[7:0];
            8'h0C: cache_q    <= acc_wdata[7:0];
            8'h0D: lat_q      <= acc_wdata[7:0];
            8'h08, 8'h0B, 8'h3D, 8'h3E, 8'h3F: ;
            default: resp_err <= 1'b1;
          endcase
        end else if (acc_size == 3'd2) begin
          case (acc_addr)
            8'h04: command_q <= acc_wdata[15:0];
            8'h06: status_q  <= acc_wdata[15:0];
            8'h0C: cache_q   <= acc_wdata[7:0];
            default: resp_err <= 1'b1;
          endcase
        end else if (bar_sel) begin
          if (!LEGACY_MASK[bar_idx]) begin
            bar_q[bar_idx] <= bar_next;
            if (!sizing && bar_raw != 32'h0) base_q[bar_idx] <= bar_raw;
          end
        end else if (acc_addr == 8'h30) begin
          rom_q <= (acc_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : acc_wdata;
        end else if (acc_addr == 8'h04) begin
          command_q <= acc_wdata[15:0];
        end
      end
    end
  end
endmodule

// File: rtl/cfg_header_regs_chk.sv
`timescale 1ns/1ps
module cfg_header_regs_chk #(
  parameter int NUM_BARS = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic                   acc_write,
  input logic [7:0]             acc_addr,
  input logic [2:0]             acc_size,
  input logic [31:0]            acc_wdata,
  input logic                   resp_valid,
  input logic                   resp_err,
  input logic [31:0]            resp_data,
  input logic [NUM_BARS*32-1:0] bar_base,
  input logic [NUM_BARS-1:0]    bar_en,
  input logic [NUM_BARS-1:0]    bar_hit
);
  logic size_ok;
  assign size_ok = acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4;

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !resp_valid); // R2
  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !size_ok) |=> (resp_err && resp_data == 32'h0)); // R4
  AST_HIGH_OFFSET_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr >= 8'h40) |=> (resp_err && resp_data == 32'h0)); // R4
  AST_BYTE_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size == 3'd1 && acc_addr < 8'h40)
      |=> (resp_data[31:8] == 24'h0 && !resp_err)); // R3
  AST_DECODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(bar_base)); // R9
  AST_SIZING_KEEPS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_size == 3'd4 && acc_wdata == 32'hFFFF_FFFF)
      |=> ($stable(bar_base) && $stable(bar_en))); // R8
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_hit & ~bar_en) == '0); // R12
endmodule

bind cfg_header_regs cfg_header_regs_chk #(.NUM_BARS(NUM_BARS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
  .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data),
  .bar_base(bar_base), .bar_en(bar_en), .bar_hit(bar_hit)
);

// File: tb/cfg_header_regs_tb_top.sv
`timescale 1ns/1ps
module cfg_header_regs_tb_top;
  localparam logic [191:0] T_BAR_INIT = {32'h1, 32'h0, 32'h0, 32'h0, 32'h1, 32'h8};
  localparam logic [191:0] T_BAR_SIZE = {32'h10, 32'h1000, 32'h0, 32'h0, 32'h20, 32'h100};
  localparam logic [5:0]   T_LEGACY   = 6'b000100;
  localparam logic [191:0] T_LEG_ADDR = {32'h0, 32'h0, 32'h0, 32'h3F8, 32'h0, 32'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [7:0] acc_addr = 8'h0;
  logic [2:0] acc_size = 3'd4;
  logic [31:0] acc_wdata = 32'h0, probe_addr = 32'h0;
  logic resp_valid, resp_err;
  logic [31:0] resp_data;
  logic [191:0] bar_base;
  logic [5:0] bar_en, bar_hit;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_header_regs #(
    .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h0A51), .CMD_INIT(16'h0000),
    .STAT_INIT(16'h0290), .REVISION(8'h03), .CLASS_CODE(24'h058012),
    .CACHE_INIT(8'h10), .LAT_INIT(8'h40), .IRQ_LINE(8'h0B), .IRQ_PIN(8'h01),
    .MIN_GNT(8'h22), .MAX_LAT(8'h33), .ROM_INIT(32'h0),
    .BAR_INIT(T_BAR_INIT), .BAR_SIZE(T_BAR_SIZE),
    .LEGACY_MASK(T_LEGACY), .LEGACY_ADDR(T_LEG_ADDR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data),
    .probe_addr(probe_addr), .bar_base(bar_base), .bar_en(bar_en), .bar_hit(bar_hit)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [2:0] s,
                        input logic [31:0] d, output logic [31:0] rd, output logic e);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R2", "resp_valid after access", {31'h0, resp_valid}, 32'h1);
    rd = resp_data; e = resp_err;
    @(negedge clk);
    chk("R2", "no response when idle", {31'h0, resp_valid}, 32'h0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [2:0] s,
                        input logic [31:0] exp);
    logic [31:0] v; logic e;
    access(1'b0, a, s, 32'h0, v, e);
    chk(req, $sformatf("read %h size %0d", a, s), v, exp);
    chk(req, "read error flag", {31'h0, e}, 32'h0);
  endtask

  task automatic wr_chk(input string req, input logic [7:0] a, input logic [2:0] s,
                        input logic [31:0] d, input logic exp_err);
    logic [31:0] v; logic e;
    access(1'b1, a, s, d, v, e);
    chk(req, $sformatf("write %h size %0d err", a, s), {31'h0, e}, {31'h0, exp_err});
  endtask

  task automatic t_reset;
    rd_chk("R1", 8'h00, 3'd4, 32'h0A51C0DE);
    rd_chk("R1", 8'h34, 3'd4, 32'h0);
    rd_chk("R1", 8'h38, 3'd4, 32'h0);
    rd_chk("R1", 8'h10, 3'd4, 32'h8);
    rd_chk("R1", 8'h0C, 3'd4, 32'h00004010);
    chk("R1", "non-legacy enables", {26'h0, bar_en & ~T_LEGACY}, 32'h0);
    chk("R10", "legacy base", bar_base[64 +: 32], 32'h3F8);
    chk("R10", "legacy enable", {31'h0, bar_en[2]}, 32'h1);
  endtask

  task automatic t_reads;
    rd_chk("R3", 8'h08, 3'd4, 32'h05801203);
    rd_chk("R3", 8'h09, 3'd1, 32'h12);
    rd_chk("R3", 8'h0A, 3'd2, 32'h0580);
    rd_chk("R3", 8'h3E, 3'd2, 32'h3322);
    rd_chk("R3", 8'h3C, 3'd4, 32'h3322010B);
    rd_chk("R3", 8'h2C, 3'd4, 32'h0001C0DF);
  endtask

  task automatic t_errors;
    logic [31:0] v; logic e;
    access(1'b0, 8'h00, 3'd3, 32'h0, v, e);
    chk("R4", "size 3 err", {31'h0, e}, 32'h1);
    chk("R4", "size 3 data", v, 32'h0);
    access(1'b0, 8'h40, 3'd4, 32'h0, v, e);
    chk("R4", "offset 0x40 err", {31'h0, e}, 32'h1);
    chk("R4", "offset 0x40 data", v, 32'h0);
    wr_chk("R4", 8'h44, 3'd4, 32'h1234, 1'b1);
    wr_chk("R4", 8'h04, 3'd0, 32'h1234, 1'b1);
    rd_chk("R4", 8'h04, 3'd2, 32'h0000);
  endtask

  task automatic t_half;
    wr_chk("R6", 8'h04, 3'd2, 32'h0146, 1'b0);
    rd_chk("R6", 8'h04, 3'd2, 32'h0146);
    wr_chk("R6", 8'h06, 3'd2, 32'h0010, 1'b0);
    rd_chk("R6", 8'h06, 3'd2, 32'h0010);
    wr_chk("R6", 8'h0C, 3'd2, 32'hABCD, 1'b0);
    rd_chk("R6", 8'h0C, 3'd4, 32'h000040CD);
    wr_chk("R6", 8'h00, 3'd2, 32'h5555, 1'b1);
    rd_chk("R6", 8'h00, 3'd2, 32'hC0DE);
  endtask

  task automatic t_word;
    wr_chk("R7", 8'h04, 3'd4, 32'h12340007, 1'b0);
    rd_chk("R7", 8'h04, 3'd4, 32'h00100007);
    wr_chk("R7", 8'h00, 3'd4, 32'hFFFFFFFF, 1'b0);
    rd_chk("R7", 8'h00, 3'd4, 32'h0A51C0DE);
    wr_chk("R7", 8'h28, 3'd4, 32'hDEADBEEF, 1'b0);
    rd_chk("R7", 8'h28, 3'd4, 32'h0);
  endtask

  task automatic t_byte;
    wr_chk("R5", 8'h3C, 3'd1, 32'h5A, 1'b0);
    rd_chk("R5", 8'h3C, 3'd1, 32'h5A);
    wr_chk("R5", 8'h0D, 3'd1, 32'h80, 1'b0);
    wr_chk("R5", 8'h0C, 3'd1, 32'h20, 1'b0);
    rd_chk("R5", 8'h0C, 3'd2, 32'h8020);
    wr_chk("R5", 8'h3D, 3'd1, 32'hFF, 1'b0);
    rd_chk("R5", 8'h3D, 3'd1, 32'h01);
    wr_chk("R5", 8'h08, 3'd1, 32'hFF, 1'b0);
    rd_chk("R5", 8'h08, 3'd1, 32'h03);
    wr_chk("R5", 8'h00, 3'd1, 32'h77, 1'b1);
    rd_chk("R5", 8'h00, 3'd2, 32'hC0DE);
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [5:0] exp);
    @(negedge clk);
    probe_addr = a;
    #1;
    chk(req, $sformatf("hit vector at %h", a), {26'h0, bar_hit}, {26'h0, exp});
  endtask

  task automatic t_bar;
    wr_chk("R8", 8'h10, 3'd4, 32'hFFFFFFFF, 1'b0);
    rd_chk("R8", 8'h10, 3'd4, 32'hFFFFFF08);
    chk("R8", "sizing leaves bar0 disabled", {31'h0, bar_en[0]}, 32'h0);
    wr_chk("R9", 8'h10, 3'd4, 32'h80000003, 1'b0);
    rd_chk("R9", 8'h10, 3'd4, 32'h80000008);
    chk("R9", "bar0 base", bar_base[0 +: 32], 32'h80000000);
    chk("R9", "bar0 enable", {31'h0, bar_en[0]}, 32'h1);
    probe("R12", 32'h800000FF, 6'b000001);
    probe("R12", 32'h80000100, 6'b000000);
    probe("R12", 32'h7FFFFFFF, 6'b000000);
    wr_chk("R8", 8'h10, 3'd4, 32'hFFFFFFFF, 1'b0);
    chk("R8", "sizing keeps bar0 base", bar_base[0 +: 32], 32'h80000000);
    wr_chk("R9", 8'h10, 3'd4, 32'h00000005, 1'b0);
    rd_chk("R9", 8'h10, 3'd4, 32'h00000008);
    chk("R9", "zero write keeps base", bar_base[0 +: 32], 32'h80000000);
    wr_chk("R9", 8'h14, 3'd4, 32'h00001003, 1'b0);
    rd_chk("R9", 8'h14, 3'd4, 32'h00001001);
    chk("R9", "bar1 io base", bar_base[32 +: 32], 32'h00001000);
    probe("R12", 32'h0000101F, 6'b000010);
    probe("R12", 32'h00001020, 6'b000000);
    wr_chk("R8", 8'h14, 3'd4, 32'hFFFFFFFF, 1'b0);
    rd_chk("R8", 8'h14, 3'd4, 32'hFFFFFFE1);
    wr_chk("R8", 8'h1C, 3'd4, 32'hFFFFFFFF, 1'b0);
    rd_chk("R8", 8'h1C, 3'd4, 32'h0);
    wr_chk("R12", 8'h1C, 3'd4, 32'h40000000, 1'b0);
    chk("R12", "zero-size bar3 base", bar_base[96 +: 32], 32'h40000000);
    probe("R12", 32'h40000000, 6'b000000);
    chk("R12", "bar4 untouched", {31'h0, bar_en[4]}, 32'h0);
  endtask

  task automatic t_legacy;
    rd_chk("R10", 8'h18, 3'd4, 32'h0);
    wr_chk("R10", 8'h18, 3'd4, 32'h12340000, 1'b0);
    rd_chk("R10", 8'h18, 3'd4, 32'h0);
    chk("R10", "legacy base fixed", bar_base[64 +: 32], 32'h3F8);
    probe("R10", 32'h000003F8, 6'b000000);
  endtask

  task automatic t_rom;
    rd_chk("R11", 8'h30, 3'd4, 32'h0);
    wr_chk("R11", 8'h30, 3'd4, 32'hFFFFFFFE, 1'b0);
    rd_chk("R11", 8'h30, 3'd4, 32'hFFFFFFFF);
    wr_chk("R11", 8'h30, 3'd4, 32'h000C0001, 1'b0);
    rd_chk("R11", 8'h30, 3'd4, 32'h000C0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_reads;
    t_errors;
    t_half;
    t_word;
    t_byte;
    t_bar;
    t_legacy;
    t_rom;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule